// File: doc/BRIEF.md
# Message-Signaled Interrupt Generator

This block turns up to 32 internal event strobes into memory-write messages for a message-signaled interrupt scheme. Software configures it through a small indexed register port. The registers are a header word holding the capability identity and control fields, a message address (upper half optional), a message data word, a per-vector mask word and a read-only pending word. Each delivered interrupt is one write request on a valid/ready message port. The request carries the programmed address and the programmed data, with the vector number merged into the low data bits.

Software allocates a power-of-two count of contiguous vectors by writing log2 of that count. An event on an allocated vector is recorded as pending. A pending vector is delivered once it is unmasked and the block is active. A masked vector therefore keeps its request until software clears the mask bit. An interlock input reports that the alternate interrupt mode is in use, and while it is high this block issues nothing.

Top module: `irq_msg_gen`

## Requirements
- R1: After reset, header word (index 0) reads 0x05 in bits 7:0, the NEXT_PTR parameter in bits 15:8, enable=0 in bit 16, the capable log2 count (MMC_LOG2) in bits 19:17, enabled log2 count=0 in bits 22:20 and the 64-bit flag (ADDR64) in bit 23. Mask (index 4) and pending (index 5) read 0, and msg_valid is 0.
- R2: Address low word (index 1) keeps bits 31:2 and reads bits 1:0 as 0. With ADDR64=1 the upper word (index 2) is writable. The message address is {upper, low}.
- R3: A write to header bits 22:20 stores min(written value, MMC_LOG2), and the stored value reads back.
- R4: An event on an allocated vector whose mask bit (index 4, bit = vector) is 1 produces no message and sets the pending bit (index 5, bit = vector).
- R5: Clearing the mask bit of a pending vector sends its message and clears its pending bit.
- R6: When enable is 0 or alt_mode_on is 1, no new message is launched and events are dropped without setting pending bits. Existing pending bits are kept.
- R7: With k the enabled log2 count, msg_data is the data word with bits k-1:0 replaced by the vector number. Events on vectors at or above 2^k are dropped.
- R8: Among deliverable vectors the lowest number is sent first, one message per accepted handshake.
- R9: While msg_valid is 1 and msg_ready is 0, msg_valid, msg_addr and msg_data stay unchanged.
- R10: An event sampled at clock edge n on an idle, unmasked vector raises msg_valid at edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| evt | input | 32 | Per-vector event strobes |
| alt_mode_on | input | 1 | Alternate interrupt mode active; blocks this block |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 16 | Message write data |

## Verification
A wrong pending bit shows at the ports in two ways. The pending word reads wrong on the very next read. A message also appears, or fails to appear, one edge after the vector becomes deliverable. A wrong stored log2 count corrupts the low data bits of the next message and changes which events are dropped. A fault in the output stage shows as data that changes while the consumer stalls, or as an order that breaks lowest-first within a burst.

// File: rtl/msig_pkg.sv
package msig_pkg;
    localparam int NVEC   = 32;
    localparam int VEC_W  = 5;
    localparam int DATA_W = 16;
    localparam logic [7:0] CAP_ID = 8'h05;

    typedef enum logic [2:0] {
        W_HDR = 3'd0,
        W_ALO = 3'd1,
        W_AHI = 3'd2,
        W_DAT = 3'd3,
        W_MSK = 3'd4,
        W_PND = 3'd5
    } widx_e;

    typedef struct packed {
        logic [63:0]       addr;
        logic [DATA_W-1:0] data;
    } msg_t;

    function automatic logic [2:0] clamp_log2(input logic [2:0] req, input logic [2:0] cap);
        return (req > cap) ? cap : req;
    endfunction

    function automatic logic [NVEC-1:0] alloc_mask(input logic [2:0] l2);
        if (l2 >= 3'd5) return '1;
        return (32'd1 << (32'd1 << l2)) - 32'd1;
    endfunction

    function automatic logic [DATA_W-1:0] merge_vec(input logic [DATA_W-1:0] base,
                                                    input logic [VEC_W-1:0] vec,
                                                    input logic [2:0] l2);
        logic [DATA_W-1:0] low;
        low = (16'd1 << l2) - 16'd1;
        return (base & ~low) | ({{(DATA_W-VEC_W){1'b0}}, vec} & low);
    endfunction
endpackage

// File: rtl/msig_regs.sv
module msig_regs
    import msig_pkg::*;
#(
    parameter bit         ADDR64   = 1'b1,
    parameter int         MMC_LOG2 = 5,
    parameter logic [7:0] NEXT_PTR = 8'h70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [2:0]        idx,
    input  logic [31:0]       wdata,
    input  logic [NVEC-1:0]   pend,
    output logic [31:0]       rdata,
    output logic              en,
    output logic [2:0]        mme,
    output logic [63:0]       addr,
    output logic [DATA_W-1:0] data,
    output logic [NVEC-1:0]   mask
);
    localparam logic [2:0] CAP_L2 = 3'(MMC_LOG2);

    logic [29:0] alo_q;
    logic [31:0] ahi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            mme   <= 3'd0;
            alo_q <= '0;
            data  <= '0;
            mask  <= '0;
        end else if (wr) begin
            case (widx_e'(idx))
                W_HDR: begin
                    en  <= wdata[16];
                    mme <= clamp_log2(wdata[22:20], CAP_L2);
                end
                W_ALO:   alo_q <= wdata[31:2];
                W_DAT:   data  <= wdata[DATA_W-1:0];
                W_MSK:   mask  <= wdata;
                default: ;
            endcase
        end
    end

    generate
        if (ADDR64) begin : g_hi
            always_ff @(posedge clk) begin
                if (rst) ahi_q <= '0;
                else if (wr && widx_e'(idx) == W_AHI) ahi_q <= wdata;
            end
        end else begin : g_nohi
            assign ahi_q = '0;
        end
    endgenerate

    assign addr = {ahi_q, alo_q, 2'b00};

    always_comb begin
        case (widx_e'(idx))
            W_HDR:   rdata = {8'h00, ADDR64, mme, CAP_L2, en, NEXT_PTR, CAP_ID};
            W_ALO:   rdata = {alo_q, 2'b00};
            W_AHI:   rdata = ahi_q;
            W_DAT:   rdata = {16'h0000, data};
            W_MSK:   rdata = mask;
            W_PND:   rdata = pend;
            default: rdata = '0;
        endcase
    end

    p_clamp_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && widx_e'(idx) == W_HDR) |=> (mme <= CAP_L2));
endmodule

// File: rtl/msig_pend.sv
module msig_pend
    import msig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NVEC-1:0]  evt,
    input  logic             active,
    input  logic [NVEC-1:0]  mask,
    input  logic [NVEC-1:0]  alloc,
    input  logic             take,
    input  logic [VEC_W-1:0] take_vec,
    output logic [NVEC-1:0]  pend,
    output logic             cand_any,
    output logic [VEC_W-1:0] cand_vec
);
    logic [NVEC-1:0] arrive, clr, cand;

    assign arrive = active ? (evt & alloc) : '0;
    assign clr    = take ? (32'd1 << take_vec) : '0;
    assign cand   = active ? (pend & ~mask & alloc) : '0;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | arrive;
    end

    always_comb begin
        cand_any = 1'b0;
        cand_vec = '0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                cand_any = 1'b1;
                cand_vec = VEC_W'(i);
            end
        end
    end

    p_masked_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (($past(pend & mask) & ~pend) == '0));

    p_drop_inactive_r6: assert property (@(posedge clk) disable iff (rst)
        !active |=> ((pend & ~$past(pend)) == '0));
endmodule

// File: rtl/msig_out.sv
module msig_out
    import msig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_any,
    input  logic [VEC_W-1:0]  cand_vec,
    input  logic [63:0]       addr,
    input  logic [DATA_W-1:0] base,
    input  logic [2:0]        l2,
    input  logic              ready,
    output logic              valid,
    output msg_t              msg,
    output logic              take,
    output logic [VEC_W-1:0]  take_vec
);
    assign take     = cand_any && (!valid || ready);
    assign take_vec = cand_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            msg   <= '0;
        end else if (take) begin
            valid    <= 1'b1;
            msg.addr <= addr;
            msg.data <= merge_vec(base, cand_vec, l2);
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    p_stable_msg_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(msg)));

    p_launch_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(cand_any));
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
    import msig_pkg::*;
#(
    parameter bit         ADDR64   = 1'b1,
    parameter int         MMC_LOG2 = 5,
    parameter logic [7:0] NEXT_PTR = 8'h70
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] evt,
    input  logic        alt_mode_on,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [63:0] msg_addr,
    output logic [15:0] msg_data
);
    logic              en;
    logic [2:0]        mme;
    logic [63:0]       addr;
    logic [DATA_W-1:0] data;
    logic [NVEC-1:0]   mask, pend;
    logic              active, cand_any, take;
    logic [VEC_W-1:0]  cand_vec, take_vec;
    msg_t              msg;

    assign active = en && !alt_mode_on;

    msig_regs #(.ADDR64(ADDR64), .MMC_LOG2(MMC_LOG2), .NEXT_PTR(NEXT_PTR)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
        .pend(pend), .rdata(reg_rdata), .en(en), .mme(mme), .addr(addr),
        .data(data), .mask(mask)
    );

    msig_pend u_pend (
        .clk(clk), .rst(rst), .evt(evt), .active(active), .mask(mask),
        .alloc(alloc_mask(mme)), .take(take), .take_vec(take_vec),
        .pend(pend), .cand_any(cand_any), .cand_vec(cand_vec)
    );

    msig_out u_out (
        .clk(clk), .rst(rst), .cand_any(cand_any), .cand_vec(cand_vec),
        .addr(addr), .base(data), .l2(mme), .ready(msg_ready),
        .valid(msg_valid), .msg(msg), .take(take), .take_vec(take_vec)
    );

    assign msg_addr = msg.addr;
    assign msg_data = msg.data;

    p_quiet_interlock_r6: assert property (@(posedge clk) disable iff (rst)
        (alt_mode_on && !msg_valid) |=> !msg_valid);
endmodule

// File: tb/irq_msg_gen_test.sv
`timescale 1ns/1ps
module irq_msg_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt = '0;
    logic        alt_mode_on = 1'b0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [63:0] msg_addr;
    logic [15:0] msg_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [63:0] ADDR_EXP = 64'h0000_0001_FEE0_1000;

    typedef struct packed {
        logic [2:0]  l2;
        logic [15:0] base;
        logic [4:0]  vec;
        logic [15:0] exp;
    } vrow_t;

    localparam vrow_t TBL [5] = '{
        '{3'd0, 16'h4ABC, 5'd0,  16'h4ABC},
        '{3'd2, 16'h4ABF, 5'd2,  16'h4ABE},
        '{3'd3, 16'h1230, 5'd5,  16'h1235},
        '{3'd5, 16'hFFFF, 5'd17, 16'hFFF1},
        '{3'd1, 16'h0002, 5'd1,  16'h0003}
    };

    always #4 clk = ~clk;

    irq_msg_gen uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
        .alt_mode_on(alt_mode_on), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] i, input logic [31:0] d);
        reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] i, output logic [31:0] d);
        reg_idx = i;
        #1 d = reg_rdata;
    endtask

    task automatic fire(input logic [31:0] v);
        evt = v;
        step(1);
        evt = '0;
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        step(1);
        msg_ready = 1'b0;
    endtask

    function automatic logic [31:0] hdr(input bit e, input logic [2:0] l2);
        return {9'd0, l2, 3'd0, e, 16'd0};
    endfunction

    initial begin
        logic [31:0] rd;
        step(3);
        rst = 1'b0;
        step(1);

        // R1: reset state and identity
        rreg(3'd0, rd); check("R1 header", rd, 32'h008A_7005);
        rreg(3'd4, rd); check("R1 mask", rd, 0);
        rreg(3'd5, rd); check("R1 pending", rd, 0);
        check("R1 valid", msg_valid, 0);

        // R2: address registers
        wreg(3'd1, 32'hFEE0_1003);
        wreg(3'd2, 32'h0000_0001);
        rreg(3'd1, rd); check("R2 addr low", rd, 32'hFEE0_1000);
        rreg(3'd2, rd); check("R2 addr high", rd, 32'h0000_0001);

        // R3: clamp of enabled count
        wreg(3'd0, hdr(1, 3'd7));
        rreg(3'd0, rd); check("R3 clamp 7", rd, 32'h00DB_7005);
        wreg(3'd0, hdr(1, 3'd6));
        rreg(3'd0, rd); check("R3 clamp 6", rd, 32'h00DB_7005);

        // R7, R10: vector table
        foreach (TBL[k]) begin
            wreg(3'd0, hdr(1, TBL[k].l2));
            wreg(3'd3, {16'h0, TBL[k].base});
            fire(32'd1 << TBL[k].vec);
            check("R10 not yet valid", msg_valid, 0);
            step(1);
            check("R10 valid", msg_valid, 1);
            check("R7 data", msg_data, TBL[k].exp);
            check("R2 msg addr", msg_addr, ADDR_EXP);
            accept();
            check("R8 drained", msg_valid, 0);
        end

        // R7: vector beyond allocation dropped
        wreg(3'd0, hdr(1, 3'd1));
        fire(32'h8);
        step(2);
        check("R7 out of range valid", msg_valid, 0);
        rreg(3'd5, rd); check("R7 out of range pending", rd, 0);

        // R4: masked events pend
        wreg(3'd0, hdr(1, 3'd5));
        wreg(3'd3, 32'h0000_A5C0);
        wreg(3'd4, 32'h0000_0014);
        fire(32'h0000_0054);
        step(1);
        check("R4 unmasked sent", msg_valid, 1);
        check("R4 unmasked data", msg_data, 16'hA5C6);
        rreg(3'd5, rd); check("R4 pending", rd, 32'h14);
        accept();
        step(2);
        check("R4 masked silent", msg_valid, 0);

        // R5, R8: unmask replays lowest first
        wreg(3'd4, 32'h0);
        step(1);
        check("R5 replay valid", msg_valid, 1);
        check("R5 R8 first", msg_data, 16'hA5C2);
        rreg(3'd5, rd); check("R5 pending after first", rd, 32'h10);
        accept();
        check("R5 R8 second", msg_data, 16'hA5C4);
        rreg(3'd5, rd); check("R5 pending cleared", rd, 0);
        accept();
        check("R5 drained", msg_valid, 0);

        // R8, R9: priority and stall
        fire(32'h0010_0208);
        step(1);
        check("R8 lowest", msg_data, 16'hA5C3);
        step(3);
        check("R9 stall valid", msg_valid, 1);
        check("R9 stall data", msg_data, 16'hA5C3);
        check("R9 stall addr", msg_addr, ADDR_EXP);
        msg_ready = 1'b1;
        step(1);
        check("R8 second", msg_data, 16'hA5C9);
        step(1);
        check("R8 third", msg_data, 16'hA5D4);
        step(1);
        check("R8 end", msg_valid, 0);
        msg_ready = 1'b0;

        // R6: disable
        wreg(3'd0, hdr(0, 3'd5));
        fire(32'h2);
        step(2);
        check("R6 disabled valid", msg_valid, 0);
        rreg(3'd5, rd); check("R6 disabled pending", rd, 0);

        // R6: interlock
        wreg(3'd0, hdr(1, 3'd5));
        alt_mode_on = 1'b1;
        fire(32'h2);
        step(2);
        check("R6 interlock valid", msg_valid, 0);
        rreg(3'd5, rd); check("R6 interlock pending", rd, 0);
        alt_mode_on = 1'b0;
        wreg(3'd4, 32'h80);
        fire(32'h80);
        alt_mode_on = 1'b1;
        wreg(3'd4, 32'h0);
        step(2);
        check("R6 held valid", msg_valid, 0);
        rreg(3'd5, rd); check("R6 held pending", rd, 32'h80);
        alt_mode_on = 1'b0;
        step(1);
        check("R6 release valid", msg_valid, 1);
        check("R6 release data", msg_data, 16'hA5C7);
        accept();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule